// File: doc/BRIEF.md
# Instruction cycle sequencer

This block is the multi-cycle control core of a small accumulator-style processor. It holds the program counter, memory address register, memory buffer register and instruction register. It steps these registers through the fetch, indirect, execute and interrupt sub-cycles over one single-port memory. Every memory access is a request that stays up until the memory answers with ready, so the block works with any memory latency.

Once the operand address is settled, the sequencer raises a one-cycle execute strobe. An external datapath uses that strobe, together with the instruction word and the resolved operand address, to carry out the operation. When the execute cycle sees an enabled, pending interrupt, the sequencer writes the return address below a stack pointer supplied from outside. It then loads the program counter from a supplied vector and pulses an acknowledge, so that the environment can drop its interrupt enable.

Top module: `icyc_seq_top`

## Requirements
- R1: A synchronous reset clears the program counter to 0, keeps the memory request, execute strobe and acknowledge low, and the first access after reset is a read at address 0.
- R2: Each fetch reads the word at the program counter address; the word is taken into the buffer register on the ready edge and then into the instruction register, so `ir_out` shows the fetched word during execute.
- R3: The program counter advances by one during every fetch, in the same edge that copies it into the address register, so that during execute `pc_out` equals the instruction's address plus one.
- R4: When bit 15 of the instruction is 1, a second read is made at the zero-extended bits 11:0 of the instruction, and the full 16-bit word returned becomes `opnd_addr`.
- R5: When bit 15 of the instruction is 0, exactly one read is made for it and `opnd_addr` is bits 11:0 of the instruction, zero-extended.
- R6: A memory request holds its address, direction and write data until ready; with L wait cycles per access, an instruction takes 4+L cycles from one execute strobe to the next when it is direct, and 6+2L cycles when it is indirect.
- R7: `exec_stb` is high for exactly one cycle per instruction.
- R8: An interrupt is taken only when `irq_req` and `irq_en` are both high in the execute cycle; a request with the enable low, or one that is present only outside the execute cycle, leaves the next fetch at the following instruction.
- R9: Taking an interrupt writes the return address (the program counter value) to address `sp_in - 1`.
- R10: After the save, `int_ack` is high for one cycle, the program counter is loaded from `vec_in`, and the next fetch reads from `vec_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write when high |
| mem_addr | output | 16 | Access address, from the address register |
| mem_wdata | output | 16 | Write data, from the buffer register |
| mem_rdata | input | 16 | Read data |
| mem_rdy | input | 1 | Memory completes the access on this edge |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| sp_in | input | 16 | Stack pointer used for the return-address save |
| vec_in | input | 16 | Interrupt routine address |
| int_ack | output | 1 | One-cycle pulse when the handler is entered |
| exec_stb | output | 1 | One-cycle execute handoff strobe |
| ir_out | output | 16 | Instruction register |
| opnd_addr | output | 16 | Resolved operand address |
| pc_out | output | 16 | Program counter |

## Verification
Two pairs of events share an edge here. The first pair is the program counter step and the copy of the old counter into the address register: right after reset the first read has to go out at address 0 while `pc_out` already reads 1. The second pair is an interrupt request and the execute strobe. The bench raises the request in exactly the execute cycle and expects the save write at `sp_in - 1` with the return address, followed by a fetch at the vector. It also raises the request with the enable low, and separately only during a fetch, and in both cases expects the next read to go to the following instruction with no acknowledge.

// File: rtl/icyc_pkg.sv
`timescale 1ns/1ps
package icyc_pkg;

  typedef enum logic [3:0] {
    ST_FADDR,   // program counter to address register, counter steps
    ST_FREAD,   // instruction read, waits for ready
    ST_FDEC,    // buffer to instruction register, indirect decision
    ST_IADDR,   // address field to address register
    ST_IREAD,   // pointer read, waits for ready
    ST_EXEC,    // one-cycle handoff, interrupt sampling
    ST_ISAVE,   // return address to buffer, stack slot to address register
    ST_IWRITE,  // save write, waits for ready
    ST_IVEC     // vector into program counter
  } seq_state_e;

  typedef struct packed {
    logic pc_step;
    logic pc_vector;
    logic mar_from_pc;
    logic mar_from_field;
    logic mar_from_sp;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic ir_from_mbr;
  } xfer_t;

endpackage

// File: rtl/icyc_fsm.sv
`timescale 1ns/1ps
module icyc_fsm
  import icyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_rdy,
  input  logic       word_indirect,
  input  logic       irq_req,
  input  logic       irq_en,
  output xfer_t      ctl,
  output logic       mem_req,
  output logic       mem_we,
  output logic       exec_stb,
  output logic       int_ack,
  output seq_state_e state_q
);

  seq_state_e state_d;
  logic       take_irq;

  assign take_irq = irq_req && irq_en;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FADDR;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d  = state_q;
    ctl      = '0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    exec_stb = 1'b0;
    int_ack  = 1'b0;
    unique case (state_q)
      ST_FADDR: begin
        ctl.mar_from_pc = 1'b1;
        ctl.pc_step     = 1'b1;
        state_d         = ST_FREAD;
      end
      ST_FREAD: begin
        mem_req = 1'b1;
        if (mem_rdy) begin
          ctl.mbr_from_mem = 1'b1;
          state_d          = ST_FDEC;
        end
      end
      ST_FDEC: begin
        ctl.ir_from_mbr = 1'b1;
        state_d         = word_indirect ? ST_IADDR : ST_EXEC;
      end
      ST_IADDR: begin
        ctl.mar_from_field = 1'b1;
        state_d            = ST_IREAD;
      end
      ST_IREAD: begin
        mem_req = 1'b1;
        if (mem_rdy) begin
          ctl.mbr_from_mem = 1'b1;
          state_d          = ST_EXEC;
        end
      end
      ST_EXEC: begin
        exec_stb = 1'b1;
        state_d  = take_irq ? ST_ISAVE : ST_FADDR;
      end
      ST_ISAVE: begin
        ctl.mbr_from_pc = 1'b1;
        ctl.mar_from_sp = 1'b1;
        state_d         = ST_IWRITE;
      end
      ST_IWRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_rdy) state_d = ST_IVEC;
      end
      ST_IVEC: begin
        ctl.pc_vector = 1'b1;
        int_ack       = 1'b1;
        state_d       = ST_FADDR;
      end
      default: state_d = ST_FADDR;
    endcase
  end

  // R7: the handoff strobe never lasts two cycles
  assert_exec_single_R7: assert property (@(posedge clk) disable iff (rst)
    exec_stb |=> !exec_stb);

  // R10: acknowledge is a single pulse and is followed by a fetch
  assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> (!int_ack && state_q == ST_FADDR));

  // R8: a save write can only follow an execute cycle with an enabled request
  assert_save_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ISAVE) |-> ($past(exec_stb) && $past(irq_req) && $past(irq_en)));

endmodule

// File: rtl/icyc_regs.sv
`timescale 1ns/1ps
module icyc_regs
  import icyc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 12,
  parameter int IND_POS = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_t             ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] vec_in,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [ADDR_W-1:0] opnd_addr,
  output logic              word_indirect
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] stack_slot(input logic [ADDR_W-1:0] sp);
    return sp - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] field_zext(input logic [DATA_W-1:0] w);
    return ADDR_W'(w[FIELD_W-1:0]);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ctl.pc_vector)    pc_q <= vec_in;
      else if (ctl.pc_step) pc_q <= step_addr(pc_q);

      if (ctl.mar_from_pc)         mar_q <= pc_q;
      else if (ctl.mar_from_field) mar_q <= field_zext(mbr_q);
      else if (ctl.mar_from_sp)    mar_q <= stack_slot(sp_in);

      if (ctl.mbr_from_mem)     mbr_q <= mem_rdata;
      else if (ctl.mbr_from_pc) mbr_q <= DATA_W'(pc_q);

      if (ctl.ir_from_mbr) ir_q <= mbr_q;
    end
  end

  assign word_indirect = mbr_q[IND_POS];
  assign opnd_addr     = ir_q[IND_POS] ? ADDR_W'(mbr_q) : field_zext(ir_q);

  // R2: the instruction register takes what the buffer held
  assert_ir_from_buffer_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.ir_from_mbr |=> (ir_q == $past(mbr_q)));

endmodule

// File: rtl/icyc_seq_top.sv
`timescale 1ns/1ps
module icyc_seq_top
  import icyc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 12,
  parameter int IND_POS = 15
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  input  logic              irq_req,
  input  logic              irq_en,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] vec_in,
  output logic              int_ack,
  output logic              exec_stb,
  output logic [DATA_W-1:0] ir_out,
  output logic [ADDR_W-1:0] opnd_addr,
  output logic [ADDR_W-1:0] pc_out
);

  xfer_t             ctl;
  seq_state_e        fsm_state;
  logic              word_indirect;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q;
  logic [DATA_W-1:0] ir_q;

  icyc_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .mem_rdy       (mem_rdy),
    .word_indirect (word_indirect),
    .irq_req       (irq_req),
    .irq_en        (irq_en),
    .ctl           (ctl),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .exec_stb      (exec_stb),
    .int_ack       (int_ack),
    .state_q       (fsm_state)
  );

  icyc_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .FIELD_W (FIELD_W),
    .IND_POS (IND_POS)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .ctl           (ctl),
    .mem_rdata     (mem_rdata),
    .sp_in         (sp_in),
    .vec_in        (vec_in),
    .pc_q          (pc_q),
    .mar_q         (mar_q),
    .mbr_q         (mbr_q),
    .ir_q          (ir_q),
    .opnd_addr     (opnd_addr),
    .word_indirect (word_indirect)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign ir_out    = ir_q;
  assign pc_out    = pc_q;

  // R6: an open request is frozen until the memory answers
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R3: while the instruction read is open the counter is one ahead of it
  assert_pc_ahead_R3: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_FREAD) |-> (pc_q == mar_q + ADDR_W'(1)));

  // R9: the save write carries the return address
  assert_save_data_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata == DATA_W'(pc_q)));

  // R10: the cycle after the acknowledge the counter holds the vector
  assert_vector_load_R10: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> (pc_q == $past(vec_in)));

endmodule

// File: tb/icyc_seq_top_tb_top.sv
`timescale 1ns/1ps
module icyc_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_req = 1'b0;
  logic        irq_en  = 1'b0;
  logic [15:0] sp_in   = 16'h0300;
  logic [15:0] vec_in  = 16'h0040;
  logic        int_ack, exec_stb;
  logic [15:0] ir_out, opnd_addr, pc_out;

  int checks = 0;
  int fails  = 0;
  int lat_cur = 0;
  int wcnt = 0;
  int cyc = 0;
  int rd_cnt = 0;
  int exec_cnt = 0;
  int ack_cnt = 0;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [0:1023] = '{default: 16'h0000};

  always #2.5 clk = ~clk;

  icyc_seq_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .sp_in     (sp_in),
    .vec_in    (vec_in),
    .int_ack   (int_ack),
    .exec_stb  (exec_stb),
    .ir_out    (ir_out),
    .opnd_addr (opnd_addr),
    .pc_out    (pc_out)
  );

  // memory model: lat_cur wait cycles per access
  assign mem_rdy   = mem_req && (wcnt == lat_cur);
  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_rdy) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_req && mem_we && mem_rdy) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_req && !mem_we && mem_rdy) rd_cnt <= rd_cnt + 1;
    if (exec_stb) exec_cnt <= exec_cnt + 1;
    if (int_ack) ack_cnt <= ack_cnt + 1;
  end

  // stimulus: instruction word, pointer word, wait cycles
  localparam int NV = 6;
  localparam logic [15:0] V_WORD [NV] = '{16'h1123, 16'h8200, 16'h0FFF,
                                          16'h8201, 16'h7000, 16'h8FFF};
  localparam logic [15:0] V_PTR  [NV] = '{16'h0000, 16'h0ABC, 16'h0000,
                                          16'hFFFE, 16'h0000, 16'h1234};
  localparam int          V_LAT  [NV] = '{0, 1, 3, 0, 2, 2};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_exec();
    do @(negedge clk); while (exec_stb !== 1'b1);
  endtask

  task automatic wait_req();
    do @(negedge clk); while (mem_req !== 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int last_exec;
    int rd_prev;
    int exp_delta;
    logic [15:0] exp_opnd;

    for (int i = 0; i < NV; i++) begin
      load_word(10'(i), V_WORD[i]);
      if (V_WORD[i][15]) load_word(V_WORD[i][9:0], V_PTR[i]);
    end
    load_word(10'h040, 16'h0055);
    lat_cur = V_LAT[0];

    // R1: reset state
    chk("R1 pc at reset", 32'(pc_out), 32'h0);
    chk("R1 no request at reset", 32'(mem_req), 32'h0);
    chk("R1 no strobes at reset", 32'({exec_stb, int_ack}), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    // R1/R3: first read at 0 while the counter already reads 1
    chk("R1 first read address", 32'({mem_req, mem_we, mem_addr}), 32'h2_0000);
    chk("R3 counter stepped with first fetch", 32'(pc_out), 32'h1);

    last_exec = 0;
    rd_prev   = 0;
    for (int i = 0; i < NV; i++) begin
      wait_exec();
      exp_opnd = V_WORD[i][15] ? V_PTR[i] : {4'h0, V_WORD[i][11:0]};
      chk("R2 instruction word", 32'(ir_out), 32'(V_WORD[i]));
      chk("R3 counter in execute", 32'(pc_out), 32'(i + 1));
      if (V_WORD[i][15]) begin
        chk("R4 indirect operand", 32'(opnd_addr), 32'(exp_opnd));
        chk("R4 two reads", 32'(rd_cnt - rd_prev), 32'd2);
      end else begin
        chk("R5 direct operand", 32'(opnd_addr), 32'(exp_opnd));
        chk("R5 one read", 32'(rd_cnt - rd_prev), 32'd1);
      end
      if (i > 0) begin
        exp_delta = V_WORD[i][15] ? 6 + 2 * V_LAT[i] : 4 + V_LAT[i];
        chk("R6 cycle length", 32'(cyc - last_exec), 32'(exp_delta));
      end
      chk("R7 one strobe per instruction", 32'(exec_cnt), 32'(i));
      last_exec = cyc;
      rd_prev   = rd_cnt;
      lat_cur   = (i + 1 < NV) ? V_LAT[i + 1] : 0;
    end

    // R8: request held with the enable low
    irq_en  = 1'b0;
    irq_req = 1'b1;
    wait_exec();
    wait_req();
    chk("R8 disabled request ignored", 32'({mem_we, mem_addr}), 32'h0_0007);

    // R8: enabled request present only during a fetch
    irq_en = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    wait_exec();
    wait_req();
    chk("R8 fetch-time request ignored", 32'({mem_we, mem_addr}), 32'h0_0008);
    chk("R8 no acknowledge", 32'(ack_cnt), 32'h0);

    // R9/R10: request in exactly the execute cycle, slow save write
    wait_exec();
    lat_cur = 2;
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    wait_req();
    chk("R9 save is a write", 32'(mem_we), 32'h1);
    chk("R9 save address", 32'(mem_addr), 32'h02FF);
    chk("R9 save data", 32'(mem_wdata), 32'h0009);
    do @(negedge clk); while (int_ack !== 1'b1);
    irq_en = 1'b0;
    chk("R9 return address stored", 32'(mem[10'h2FF]), 32'h0009);
    @(negedge clk);
    chk("R10 counter holds vector", 32'(pc_out), 32'h0040);
    chk("R10 acknowledge is one cycle", 32'(int_ack), 32'h0);
    wait_req();
    chk("R10 fetch from vector", 32'({mem_we, mem_addr}), 32'h0_0040);
    wait_exec();
    chk("R10 handler word", 32'(ir_out), 32'h0055);
    chk("R10 single acknowledge", 32'(ack_cnt), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule